// File: doc/BRIEF.md
# Fractional Tick Divider

This block turns a slow source clock into a periodic tick at a frequency that need not divide the source rate evenly. The source clock, for example a 32.768 kHz real-time clock, enters as a one-cycle enable on the fast system clock. Each enabled cycle is one source period. Software programs an integer reload value and a 16-bit fraction. The block then produces a square wave whose half-periods last either the base count or one source period longer. A phase accumulator makes that choice, so the long-term rate is exact even though single periods jitter and the duty cycle changes from period to period.

To program it, compute V = f_source / 2 / f_target. Write the integer part minus one to the integer register and the fractional part times 65536 to the fraction register. For a 9 kHz source and a 2 kHz target, V is 2.25, so the integer register holds 1 and the fraction register holds 16384. The source must run at least four times faster than the target, so the integer register must be at least 1. Fractional operation runs only while the mode bit is 1 and the bypass bit is 0. The block also gives a pulse on the start of every high half-period, which is once per full output period.

Top module: `frac_tick_divider`

## Requirements
- R1: After a synchronous reset, `wave_out` and `tick_out` are 0, and both the integer and the fraction register hold 0.
- R2: With a fraction of 0 and an integer value N, every half-period of `wave_out` lasts exactly N+1 source-enable cycles.
- R3: At the end of each half-period the fraction is added to a 16-bit accumulator that starts at 0. If that addition carries out of bit 15, the next half-period lasts one source-enable cycle longer than N+1. Otherwise it lasts N+1. With N=1 and fraction 16384, the half-periods after a restart therefore run 2,2,2,2,3,2,2,2,3,…
- R4: `tick_out` is high exactly while `wave_out` is high and the current half-period has not yet seen a source-enable. This gives one tick per rising edge of `wave_out`, and the tick begins in the same cycle as that rising edge.
- R5: A write to either register clears the counter and the accumulator and drives `wave_out` low in the next cycle. The half-period that then begins uses the new value.
- R6: When `mode_en` is 0 or `bypass_en` is 1, `wave_out` and `tick_out` stay 0 and the counter and accumulator are held cleared. On re-enable, a fresh half-period starts with the accumulator at 0.
- R7: `wave_out` changes only in a cycle that follows a cycle where `src_en` was high, apart from the clears of R5 and R6.
- R8: Over any 40 consecutive half-periods with N=1 and fraction 16384, the total length is exactly 90 source-enable cycles, so the long-term rate has no error.
- R9: `wr_sel` picks the register to write: 0 selects the integer register (low 16 bits of `wr_data`) and 1 selects the fraction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_en | input | 1 | One-cycle enable per source clock period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 integer, 1 fraction |
| wr_data | input | 16 | Write data |
| mode_en | input | 1 | Fractional mode enable |
| bypass_en | input | 1 | Must be 0 for fractional operation |
| wave_out | output | 1 | Divided square wave |
| tick_out | output | 1 | Pulse at the start of each high half-period |

## Verification
The block is first driven with a zero fraction and a continuous source enable. Equal half-periods there separate the base count from the accumulator path. The example fraction 16384 then has to produce the 2,2,2,2,3 pattern and the exact 90-cycle total, which shows whether the carry lands on the right half-period and whether the sum wraps. A sparse source enable with a large odd fraction shows whether counting follows the enable rather than the system clock and whether carries chain from one half to the next. Writes in mid-run and toggling of the mode and bypass bits show whether the restart and idle behaviour clear all state.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
   typedef enum logic {
      SEL_INT  = 1'b0,
      SEL_FRAC = 1'b1
   } reg_sel_e;

   localparam int unsigned DEF_INT_W  = 16;
   localparam int unsigned DEF_FRAC_W = 16;
endpackage

// File: rtl/ftd_cfg_regs.sv
module ftd_cfg_regs
   import ftd_pkg::*;
#(
   parameter int unsigned INT_W  = DEF_INT_W,
   parameter int unsigned FRAC_W = DEF_FRAC_W,
   localparam int unsigned DATA_W = (INT_W > FRAC_W) ? INT_W : FRAC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [INT_W-1:0]  int_q,
   output logic [FRAC_W-1:0] frac_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         int_q  <= '0;
         frac_q <= '0;
      end else if (wr_en) begin
         if (reg_sel_e'(wr_sel) == SEL_FRAC)
            frac_q <= wr_data[FRAC_W-1:0];
         else
            int_q <= wr_data[INT_W-1:0];
      end
   end
endmodule

// File: rtl/ftd_phase_acc.sv
module ftd_phase_acc #(
   parameter int unsigned FRAC_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              advance,
   input  logic [FRAC_W-1:0] frac,
   output logic              stretch
);
   logic [FRAC_W-1:0] phase_q;
   logic [FRAC_W:0]   sum;

   assign sum = {1'b0, phase_q} + {1'b0, frac};

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         phase_q <= '0;
         stretch <= 1'b0;
      end else if (advance) begin
         phase_q <= sum[FRAC_W-1:0];
         stretch <= sum[FRAC_W];
      end
   end
endmodule

// File: rtl/ftd_half_counter.sv
module ftd_half_counter #(
   parameter int unsigned INT_W = 16,
   localparam int unsigned CNT_W = INT_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             step,
   input  logic [INT_W-1:0] base,
   input  logic             stretch,
   output logic             boundary,
   output logic             at_start
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_idx;

   assign last_idx = {1'b0, base} + {{(CNT_W-1){1'b0}}, stretch};
   assign boundary = step && (cnt_q == last_idx);
   assign at_start = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst || clear)
         cnt_q <= '0;
      else if (boundary)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/frac_tick_divider.sv
module frac_tick_divider
   import ftd_pkg::*;
#(
   parameter int unsigned INT_W  = DEF_INT_W,
   parameter int unsigned FRAC_W = DEF_FRAC_W,
   localparam int unsigned DATA_W = (INT_W > FRAC_W) ? INT_W : FRAC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_en,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mode_en,
   input  logic              bypass_en,
   output logic              wave_out,
   output logic              tick_out
);
   generate
      if (INT_W < 2) begin : g_bad_int
         $error("INT_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("FRAC_W must be at least 1");
      end
   endgenerate

   logic [INT_W-1:0]  int_q;
   logic [FRAC_W-1:0] frac_q;
   logic              active, clear, step, boundary, at_start, stretch;
   logic              wave_q;

   assign active = mode_en && !bypass_en;
   assign clear  = wr_en || !active;
   assign step   = src_en && active && !wr_en;

   ftd_cfg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .int_q(int_q), .frac_q(frac_q)
   );

   ftd_half_counter #(.INT_W(INT_W)) u_cnt (
      .clk(clk), .rst(rst), .clear(clear), .step(step), .base(int_q),
      .stretch(stretch), .boundary(boundary), .at_start(at_start)
   );

   ftd_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .clear(clear), .advance(boundary),
      .frac(frac_q), .stretch(stretch)
   );

   always_ff @(posedge clk) begin
      if (rst || clear)
         wave_q <= 1'b0;
      else if (boundary)
         wave_q <= !wave_q;
   end

   assign wave_out = wave_q;
   assign tick_out = wave_q && at_start;
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker (
   input logic clk,
   input logic rst,
   input logic src_en,
   input logic wr_en,
   input logic mode_en,
   input logic bypass_en,
   input logic wave_out,
   input logic tick_out
);
   p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
      (!mode_en || bypass_en) |=> (!wave_out && !tick_out));

   p_write_clear_r5: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wave_out);

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!src_en && !wr_en && mode_en && !bypass_en) |=> $stable(wave_out));

   p_tick_high_r4: assert property (@(posedge clk) disable iff (rst)
      tick_out |-> wave_out);

   p_tick_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(wave_out) |-> tick_out);
endmodule

bind frac_tick_divider ftd_checker i_chk (
   .clk(clk), .rst(rst), .src_en(src_en), .wr_en(wr_en),
   .mode_en(mode_en), .bypass_en(bypass_en),
   .wave_out(wave_out), .tick_out(tick_out)
);

// File: tb/test_frac_tick_divider.sv
module test_frac_tick_divider;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        src_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        mode_en = 1'b0, bypass_en = 1'b0;
   logic        wave_out, tick_out;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   frac_tick_divider i_frac_tick_divider (
      .clk(clk), .rst(rst), .src_en(src_en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .mode_en(mode_en), .bypass_en(bypass_en),
      .wave_out(wave_out), .tick_out(tick_out)
   );

   // behavioural reference
   longint m_int = 0, m_frac = 0, m_cnt = 0, m_acc = 0, m_extra = 0;
   bit     m_wave = 0;
   bit     meas_on = 0, last_w = 0;
   int     run = 0;
   int     halves[$];
   int     rises = 0, ticks = 0;
   bit     last_t = 0;
   string  cur_req = "R1";

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit s, act;
      s = src_en;
      act = mode_en && !bypass_en;
      if (rst) begin
         m_int = 0; m_frac = 0; m_cnt = 0; m_acc = 0; m_extra = 0; m_wave = 0;
      end else if (wr_en) begin
         if (wr_sel) m_frac = wr_data; else m_int = wr_data;   // R9
         m_cnt = 0; m_acc = 0; m_extra = 0; m_wave = 0;
      end else if (!act) begin
         m_cnt = 0; m_acc = 0; m_extra = 0; m_wave = 0;
      end else if (s) begin
         if (m_cnt == m_int + m_extra) begin
            m_wave = !m_wave;
            m_cnt = 0;
            m_acc = m_acc + m_frac;
            m_extra = (m_acc >= 65536) ? 1 : 0;
            m_acc = m_acc % 65536;
         end else m_cnt++;
      end
      #2;
      check({cur_req, " wave"}, wave_out, m_wave);
      check({cur_req, " tick"}, tick_out, (m_wave && m_cnt == 0) ? 1 : 0);
      if (meas_on) begin
         if (wave_out != last_w) begin
            halves.push_back(run + s);
            run = 0;
         end else run += s;
         if (wave_out && !last_w) rises++;
         if (tick_out && !last_t) ticks++;
      end
      last_w = wave_out;
      last_t = tick_out;
   end

   task automatic write_reg(bit sel, int data);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_data = 16'(data);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic start_meas();
      halves.delete(); run = 0; rises = 0; ticks = 0; meas_on = 1;
   endtask

   task automatic run_src(int n, int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); src_en = 1;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk); src_en = 0;
         end
      end
      @(negedge clk); src_en = 0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!finished) begin
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int sum;
      repeat (3) @(negedge clk);
      rst = 0;
      // R1: reset state; registers at 0 -> half-period of 1 source cycle
      cur_req = "R1";
      @(negedge clk); check("R1 wave", wave_out, 0); check("R1 tick", tick_out, 0);
      mode_en = 1;
      start_meas(); run_src(6, 0); meas_on = 0;
      check("R1 int reset", halves.size() >= 4 ? halves[1] : -1, 1);

      // R2/R9: integer only
      cur_req = "R2";
      write_reg(0, 3); write_reg(1, 0);
      start_meas(); run_src(30, 0); meas_on = 0;
      check("R2 halves", halves.size(), 7);
      foreach (halves[i]) check("R2 len", halves[i], 4);
      check("R4 ticks per rise", ticks, rises);

      // R3/R8/R9: example fraction
      cur_req = "R3";
      write_reg(0, 1); write_reg(1, 16384);
      start_meas(); run_src(100, 0); meas_on = 0;
      begin
         int exp_p[9] = '{2, 2, 2, 2, 3, 2, 2, 2, 3};
         for (int i = 0; i < 9; i++) check("R3 pattern", halves[i], exp_p[i]);
      end
      sum = 0;
      for (int i = 1; i <= 40; i++) sum += halves[i];
      check("R8 total 40 halves", sum, 90);
      check("R4 ticks per rise", ticks, rises);

      // R7: sparse source enable, large fraction
      cur_req = "R7";
      write_reg(0, 2); write_reg(1, 65535);
      start_meas(); run_src(120, 2); meas_on = 0;
      check("R4 ticks per rise sparse", ticks, rises);
      check("R7 some halves", halves.size() > 10, 1);

      // R5: write mid-run clears output
      cur_req = "R5";
      run_src(4, 0);
      write_reg(0, 5);
      check("R5 wave after write", wave_out, 0);
      start_meas(); run_src(40, 0); meas_on = 0;
      check("R5 new length", halves[0], 6);

      // R6: disable via mode and via bypass
      cur_req = "R6";
      run_src(3, 0);
      mode_en = 0;
      start_meas(); run_src(20, 0); meas_on = 0;
      check("R6 mode off wave", wave_out, 0);
      check("R6 mode off ticks", ticks, 0);
      mode_en = 1; bypass_en = 1;
      start_meas(); run_src(20, 0); meas_on = 0;
      check("R6 bypass ticks", ticks, 0);
      bypass_en = 0;
      start_meas(); run_src(20, 0); meas_on = 0;
      check("R6 restart len", halves[0], 6);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule